// File: doc/BRIEF.md
# Paged 24-bit address generator

This block forms the memory addresses of an 8-bit processor whose registers are 16 bits wide. Each data access has an addressing mode. The mode picks a 16-bit offset from the index registers, the stack pointer or the immediate bytes. It also picks an 8-bit page that supplies the top byte of a 24-bit address. The page registers live inside the block. They are loaded through a single write port.

Code fetches take a separate path. The 16-bit program counter maps directly into the low 32 KiB of code space. When its top bit is set, the active code bank replaces that bit, which gives a 23-bit fetch address.

The active bank cannot be written directly. Software writes a pending-bank register, and the block copies that value into the active bank only when the core signals a taken branch. A bank switch therefore takes effect at the branch target and never partway through a sequence. The external address pins carry only the low 21 bits of the data address.

Top module: `paged_addr_gen`

## Requirements
- R1: After reset, all five page registers (data page, X page, Y page, pending bank, active bank) hold 00h.
- R2: With `mode_sel`=3, `data_addr` is {X page, `ix`}. With `mode_sel`=4, it is {Y page, `iy`}.
- R3: With `mode_sel`=1, `data_addr` is {data page, `hl`}. With `mode_sel`=0, it is {data page, `imm_hi`, `imm_lo`}.
- R4: With `mode_sel`=2, `data_addr` is {data page, `br`, `imm_lo`}. For example, page 00h, `br`=20h and `imm_lo`=8Ah give 00208Ah.
- R5: With `mode_sel`=5, `data_addr` is {00h, `sp`}, whatever the data page holds.
- R6: When `pc[15]` is 0, `code_addr` is `pc` zero-extended to 23 bits. When `pc[15]` is 1, `code_addr` is {active bank, `pc[14:0]`}.
- R7: A write to the pending bank (`pg_wr_sel`=3) leaves the active bank and `code_addr` unchanged until a branch strobe arrives.
- R8: A clock edge with `branch_taken` high loads the active bank from the pending bank.
- R9: If `branch_taken` and a pending-bank write fall on the same edge, the active bank takes the old pending value and the pending bank takes the new data.
- R10: `ext_addr` always equals `data_addr[20:0]`.
- R11: A page write with `pg_wr_sel` 0, 1, 2 or 3 (data, X, Y, pending bank) changes only that register.
- R12: The unused mode codes 6 and 7 give `data_addr` = 000000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 3 | Data addressing mode |
| hl | input | 16 | HL pointer value |
| ix | input | 16 | X index value |
| iy | input | 16 | Y index value |
| sp | input | 16 | Stack pointer |
| pc | input | 16 | Program counter |
| br | input | 8 | Base register (middle byte) |
| imm_hi | input | 8 | Immediate high byte |
| imm_lo | input | 8 | Immediate low byte |
| pg_wr_en | input | 1 | Page register write enable |
| pg_wr_sel | input | 2 | Page register select: 0 data, 1 X, 2 Y, 3 pending bank |
| pg_wr_data | input | 8 | Page write value |
| branch_taken | input | 1 | Branch strobe, loads active bank |
| data_addr | output | 24 | Data access address |
| ext_addr | output | 21 | Address bits driven to pins |
| code_addr | output | 23 | Code fetch address |

## Verification
Some properties hold on every cycle, and the assertions check those. They cover the bank transfer on a branch and the holding of the active bank between branches. They also cover the pending-bank capture, the persistence of the data page, the zero page of the stack mode, the pin truncation and the pass-through of the low fetch bits.

Other behaviour shows up only in the bench scenarios. These cover how each mode combines register contents with random offsets, and the same-edge collision of a branch and a pending-bank write. They also cover the reset values and the isolation between page registers, which the bench observes through the address outputs.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int PAGE_W = 8;
    localparam int OFS_W  = 16;
    localparam int ADDR_W = PAGE_W + OFS_W;
    localparam int CODE_W = ADDR_W - 1;
    localparam int EXT_W  = 21;

    typedef enum logic [2:0] {
        AM_ABS = 3'd0,
        AM_HL  = 3'd1,
        AM_BR  = 3'd2,
        AM_IX  = 3'd3,
        AM_IY  = 3'd4,
        AM_SP  = 3'd5
    } amode_e;

    typedef enum logic [1:0] {
        PG_DATA = 2'd0,
        PG_X    = 2'd1,
        PG_Y    = 2'd2,
        PG_NEXT = 2'd3
    } pgsel_e;

    typedef struct packed {
        logic [PAGE_W-1:0] dp;
        logic [PAGE_W-1:0] xp;
        logic [PAGE_W-1:0] yp;
        logic [PAGE_W-1:0] nxt;
        logic [PAGE_W-1:0] bank;
    } pages_t;
endpackage

// File: rtl/agu_page_regs.sv
module agu_page_regs
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic              branch,
    output pages_t            pages
);
    pages_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        // active bank follows the pending value only on a branch (old value on collision)
        if (branch) pg_d.bank = pg_q.nxt;
        if (wr_en) begin
            unique case (pgsel_e'(wr_sel))
                PG_DATA: pg_d.dp  = wr_data;
                PG_X:    pg_d.xp  = wr_data;
                PG_Y:    pg_d.yp  = wr_data;
                PG_NEXT: pg_d.nxt = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign pages = pg_q;
endmodule

// File: rtl/agu_data_mux.sv
module agu_data_mux
    import agu_pkg::*;
(
    input  logic [2:0]        mode,
    input  pages_t            pages,
    input  logic [OFS_W-1:0]  hl,
    input  logic [OFS_W-1:0]  ix,
    input  logic [OFS_W-1:0]  iy,
    input  logic [OFS_W-1:0]  sp,
    input  logic [PAGE_W-1:0] br,
    input  logic [PAGE_W-1:0] imm_hi,
    input  logic [PAGE_W-1:0] imm_lo,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        unique case (amode_e'(mode))
            AM_ABS:  addr = {pages.dp, imm_hi, imm_lo};
            AM_HL:   addr = {pages.dp, hl};
            AM_BR:   addr = {pages.dp, br, imm_lo};
            AM_IX:   addr = {pages.xp, ix};
            AM_IY:   addr = {pages.yp, iy};
            AM_SP:   addr = {{PAGE_W{1'b0}}, sp};
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/agu_code_map.sv
module agu_code_map
    import agu_pkg::*;
(
    input  logic [OFS_W-1:0]  pc,
    input  logic [PAGE_W-1:0] bank,
    output logic [CODE_W-1:0] code_addr
);
    localparam int LOW_W = OFS_W - 1;

    always_comb begin
        if (pc[OFS_W-1]) code_addr = {bank, pc[LOW_W-1:0]};
        else             code_addr = {{(CODE_W-OFS_W){1'b0}}, pc};
    end
endmodule

// File: rtl/paged_addr_gen.sv
module paged_addr_gen
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic [OFS_W-1:0]  hl,
    input  logic [OFS_W-1:0]  ix,
    input  logic [OFS_W-1:0]  iy,
    input  logic [OFS_W-1:0]  sp,
    input  logic [OFS_W-1:0]  pc,
    input  logic [PAGE_W-1:0] br,
    input  logic [PAGE_W-1:0] imm_hi,
    input  logic [PAGE_W-1:0] imm_lo,
    input  logic              pg_wr_en,
    input  logic [1:0]        pg_wr_sel,
    input  logic [PAGE_W-1:0] pg_wr_data,
    input  logic              branch_taken,
    output logic [ADDR_W-1:0] data_addr,
    output logic [EXT_W-1:0]  ext_addr,
    output logic [CODE_W-1:0] code_addr
);
    pages_t pages;

    agu_page_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pg_wr_en),
        .wr_sel  (pg_wr_sel),
        .wr_data (pg_wr_data),
        .branch  (branch_taken),
        .pages   (pages)
    );

    agu_data_mux u_dmux (
        .mode   (mode_sel),
        .pages  (pages),
        .hl     (hl),
        .ix     (ix),
        .iy     (iy),
        .sp     (sp),
        .br     (br),
        .imm_hi (imm_hi),
        .imm_lo (imm_lo),
        .addr   (data_addr)
    );

    agu_code_map u_cmap (
        .pc        (pc),
        .bank      (pages.bank),
        .code_addr (code_addr)
    );

    generate
        if (EXT_W < ADDR_W) begin : g_trunc
            assign ext_addr = data_addr[EXT_W-1:0];
        end else begin : g_full
            assign ext_addr = EXT_W'(data_addr);
        end
    endgenerate
endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_sel,
    input logic [OFS_W-1:0]  sp,
    input logic [OFS_W-1:0]  pc,
    input logic              pg_wr_en,
    input logic [1:0]        pg_wr_sel,
    input logic [PAGE_W-1:0] pg_wr_data,
    input logic              branch_taken,
    input logic [PAGE_W-1:0] bank,
    input logic [PAGE_W-1:0] nxt,
    input logic [PAGE_W-1:0] dp,
    input logic [ADDR_W-1:0] data_addr,
    input logic [EXT_W-1:0]  ext_addr,
    input logic [CODE_W-1:0] code_addr
);
    p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !branch_taken |=> $stable(bank));

    p_bank_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |=> bank == $past(nxt));

    p_next_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_wr_en && pg_wr_sel == 2'd3) |=> nxt == $past(pg_wr_data));

    p_dp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pg_wr_en && pg_wr_sel == 2'd0) |=> $stable(dp));

    p_stack_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 3'd5 |-> (data_addr[ADDR_W-1:OFS_W] == '0 && data_addr[OFS_W-1:0] == sp));

    p_pin_trunc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_addr == data_addr[EXT_W-1:0]);

    p_fetch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        code_addr[OFS_W-2:0] == pc[OFS_W-2:0]);
endmodule

bind paged_addr_gen agu_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .sp           (sp),
    .pc           (pc),
    .pg_wr_en     (pg_wr_en),
    .pg_wr_sel    (pg_wr_sel),
    .pg_wr_data   (pg_wr_data),
    .branch_taken (branch_taken),
    .bank         (pages.bank),
    .nxt          (pages.nxt),
    .dp           (pages.dp),
    .data_addr    (data_addr),
    .ext_addr     (ext_addr),
    .code_addr    (code_addr)
);

// File: tb/sim_paged_addr_gen.sv
`timescale 1ns/1ps
module sim_paged_addr_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  mode_sel = 0;
    logic [15:0] hl = 0, ix = 0, iy = 0, sp = 0, pc = 0;
    logic [7:0]  br = 0, imm_hi = 0, imm_lo = 0;
    logic        pg_wr_en = 0;
    logic [1:0]  pg_wr_sel = 0;
    logic [7:0]  pg_wr_data = 0;
    logic        branch_taken = 0;
    logic [23:0] data_addr;
    logic [20:0] ext_addr;
    logic [22:0] code_addr;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] m_dp = 0, m_xp = 0, m_yp = 0, m_nxt = 0, m_bank = 0;

    always #2.5 clk = ~clk;

    paged_addr_gen u0 (.*);

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_data(logic [2:0] m);
        case (m)
            3'd0: return {m_dp, imm_hi, imm_lo};
            3'd1: return {m_dp, hl};
            3'd2: return {m_dp, br, imm_lo};
            3'd3: return {m_xp, ix};
            3'd4: return {m_yp, iy};
            3'd5: return {8'h00, sp};
            default: return 24'h0;
        endcase
    endfunction

    function automatic logic [22:0] ref_code();
        return pc[15] ? {m_bank, pc[14:0]} : {7'd0, pc};
    endfunction

    task automatic write_page(logic [1:0] sel, logic [7:0] v);
        @(negedge clk);
        pg_wr_en = 1; pg_wr_sel = sel; pg_wr_data = v;
        @(negedge clk);
        pg_wr_en = 0;
        case (sel)
            2'd0: m_dp = v;
            2'd1: m_xp = v;
            2'd2: m_yp = v;
            default: m_nxt = v;
        endcase
    endtask

    task automatic do_branch(bit with_wr, logic [7:0] v);
        @(negedge clk);
        branch_taken = 1;
        if (with_wr) begin pg_wr_en = 1; pg_wr_sel = 2'd3; pg_wr_data = v; end
        @(negedge clk);
        branch_taken = 0; pg_wr_en = 0;
        m_bank = m_nxt;
        if (with_wr) m_nxt = v;
    endtask

    task automatic randomize_ofs();
        hl = 16'($urandom); ix = 16'($urandom); iy = 16'($urandom);
        sp = 16'($urandom); br = 8'($urandom);
        imm_hi = 8'($urandom); imm_lo = 8'($urandom);
    endtask

    task automatic t_reset();
        // R1: every page reads as 00h through its mode
        ix = 16'h1234; iy = 16'h5678; hl = 16'h9ABC; pc = 16'hC001;
        mode_sel = 3'd3; #1 chk("R1 xp", data_addr, 24'h001234);
        mode_sel = 3'd4; #1 chk("R1 yp", data_addr, 24'h005678);
        mode_sel = 3'd1; #1 chk("R1 dp", data_addr, 24'h009ABC);
        #1 chk("R1 bank", {1'b0, code_addr}, 24'h004001);
        do_branch(0, 0);
        #1 chk("R1 nxt", {1'b0, code_addr}, 24'h004001);
    endtask

    task automatic t_modes();
        for (int i = 0; i < 24; i++) begin
            write_page(2'(i % 3), 8'($urandom));
            randomize_ofs();
            for (int m = 0; m < 6; m++) begin
                mode_sel = 3'(m);
                #1;
                case (m)
                    0, 1: chk("R3 dp modes", data_addr, ref_data(3'(m)));
                    2:    chk("R4 base mode", data_addr, ref_data(3'(m)));
                    3, 4: chk("R2 index modes", data_addr, ref_data(3'(m)));
                    default: chk("R5 stack page", data_addr, ref_data(3'(m)));
                endcase
                chk("R10 pins", {3'b0, ext_addr}, {3'b0, data_addr[20:0]});
            end
        end
    endtask

    task automatic t_base_example();
        write_page(2'd0, 8'h00);
        br = 8'h20; imm_lo = 8'h8A; mode_sel = 3'd2;
        #1 chk("R4 example", data_addr, 24'h00208A);
        write_page(2'd0, 8'hFF);
        sp = 16'h1F80; mode_sel = 3'd5;
        #1 chk("R5 page ignored", data_addr, 24'h001F80);
    endtask

    task automatic t_unused();
        write_page(2'd1, 8'hA5);
        randomize_ofs();
        mode_sel = 3'd6; #1 chk("R12 code6", data_addr, 24'h0);
        mode_sel = 3'd7; #1 chk("R12 code7", data_addr, 24'h0);
    endtask

    task automatic t_code();
        pc = 16'h7FFF; #1 chk("R6 low half", {1'b0, code_addr}, 24'h007FFF);
        write_page(2'd3, 8'h5A);
        pc = 16'h8123; #1 chk("R7 bank not yet", {1'b0, code_addr}, {1'b0, ref_code()});
        do_branch(0, 0);
        #1 chk("R8 bank loaded", {1'b0, code_addr}, {1'b0, 8'h5A, 15'h0123});
        pc = 16'h0123; #1 chk("R6 bank unused", {1'b0, code_addr}, 24'h000123);
        pc = 16'hFFFF; #1 chk("R6 high half", {1'b0, code_addr}, {1'b0, ref_code()});
    endtask

    task automatic t_collision();
        write_page(2'd3, 8'h11);
        pc = 16'h8000;
        do_branch(1, 8'h77);
        #1 chk("R9 old value", {1'b0, code_addr}, {1'b0, 8'h11, 15'h0});
        do_branch(0, 0);
        #1 chk("R9 new pending", {1'b0, code_addr}, {1'b0, 8'h77, 15'h0});
    endtask

    task automatic t_isolation();
        write_page(2'd0, 8'h10); write_page(2'd1, 8'h20); write_page(2'd2, 8'h30);
        write_page(2'd3, 8'h40);
        hl = 16'h0001; ix = 16'h0002; iy = 16'h0003; pc = 16'h8004;
        mode_sel = 3'd1; #1 chk("R11 dp", data_addr, 24'h100001);
        mode_sel = 3'd3; #1 chk("R11 xp", data_addr, 24'h200002);
        mode_sel = 3'd4; #1 chk("R11 yp", data_addr, 24'h300003);
        #1 chk("R11 bank", {1'b0, code_addr}, {1'b0, ref_code()});
        write_page(2'd1, 8'hEE);
        mode_sel = 3'd1; #1 chk("R11 dp after xp write", data_addr, 24'h100001);
        mode_sel = 3'd4; #1 chk("R11 yp after xp write", data_addr, 24'h300003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R1 reset addr", data_addr, 24'h0);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_base_example();
        t_unused();
        t_code();
        t_collision();
        t_isolation();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule